// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block is a master for a three-wire serial link to a peripheral that holds a bank of 16-bit registers. The link has three wires: a clock, a single data wire used in both directions, and an active-low enable. A client hands the block one request at a time on a valid/ready interface. A request holds a read/write flag, a 7-bit register address and a 16-bit write value. The block then runs the whole link sequence by itself and reports the end with a one-cycle done pulse. For a read, the captured 16-bit value is valid during that pulse.

The link sequence has more steps than a plain serial shift. The block first gives two clock pulses while the enable is still high. It then pulls the enable low and shifts out a 9-bit header, most significant bit first. A read adds one turnaround pulse with the data pad released. After that come 16 data pulses. The enable then returns high after half a clock period, and one final clock pulse ends the sequence. The block provides an output-enable signal for the bidirectional data pad. It also holds the peripheral's active-low reset output high once the block is out of reset. A parameter sets how many system clocks each half of the serial clock lasts.

Top module: `tws_master`

## Requirements
- R1: During and right after reset the link is idle: enable high, serial clock low, data pad driven (output enable 1), busy low, ready high, done low. The peripheral reset output is low while the block is in reset and high afterwards.
- R2: Every high phase and every low phase of the serial clock lasts HALF_CYC system clocks, apart from the half-period gap of R7. The serial clock is low whenever no transaction is running.
- R3: After a request is accepted, exactly two full serial clock pulses happen with the enable high, before the enable goes low.
- R4: The header is 9 bits, most significant bit first. Bit 8 is 0, bit 7 is the read flag (1 = read, 0 = write) and bits 6:0 are the register address. Each bit is on the data wire before the clock rises and stays there through that pulse.
- R5: A write sends the 16-bit write value most significant bit first, right after the header. The data pad stays driven for the whole transaction.
- R6: On a read, the data pad is released after the 9 header bits, and one turnaround pulse follows. Then come 16 pulses. The input is sampled at each falling clock edge and shifted into the least significant bit. The resulting word is on rdata_o while done is high.
- R7: After the last data pulse, the clock stays low for HALF_CYC system clocks. The enable then rises and the pad is driven again. Exactly one more clock pulse follows while the enable is high.
- R8: busy is high from the cycle after acceptance until the trailing pulse has finished. done is high for exactly one cycle, in the cycle busy falls.
- R9: A request with an address of NUM_REGS (31) or more is accepted and answered with done and err high together for one cycle. The link shows no clock pulse and no enable activity for it.
- R10: While a transaction is in progress, ready is low and any request presented is ignored. It causes no extra link activity and no extra done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | ADDR_W (7) | Register address |
| req_wdata_i | input | DATA_W (16) | Write value |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With done: address was rejected |
| rdata_o | output | DATA_W (16) | Captured read word, valid with done after a read |
| link_clk_o | output | 1 | Serial clock, idles low |
| link_en_no | output | 1 | Active-low link enable |
| link_dat_o | output | 1 | Data wire output value |
| link_dat_oe_o | output | 1 | Data pad output enable (1 = drive) |
| link_dat_i | input | 1 | Data wire input value |
| link_rst_no | output | 1 | Active-low peripheral reset, high after reset |

## Verification
The hardest part to reach is the read phase. There, data on the wire comes from the peripheral, and it must follow the turnaround pulse by exactly one pulse. The bench contains a small peripheral model driven only by the link pins. The model counts rising edges while the pad is released and puts the next bit of its stored register on the input after each rise. This way a wrong turnaround count or a wrong sampling edge shows up as a wrong returned word. The model also stores written words, so read-back values depend on earlier writes going through the link correctly. Requests presented while busy are driven on purpose in the middle of a transaction, to check that the ready gate holds.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_TURN,
    ST_DATA,
    ST_GAP,
    ST_POST
  } seq_state_e;

  // header word: leading zero, read flag, then address bits (right aligned)
  function automatic logic [31:0] frame_header(input logic rd, input logic [31:0] addr,
                                               input int aw);
    logic [31:0] mask;
    mask = (32'd1 << aw) - 32'd1;
    return (32'(rd) << aw) | (addr & mask);
  endfunction

  function automatic logic addr_valid(input logic [31:0] addr, input int nregs);
    return addr < 32'(nregs);
  endfunction

endpackage

// File: rtl/tws_clkgen.sv
module tws_clkgen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_low_i,
  output logic sclk_o,
  output logic half_tick_o,
  output logic slot_end_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          tick;

  assign tick        = run_i && (cnt_q == CW'(HALF_CYC - 1));
  assign half_tick_o = tick;
  assign slot_end_o  = tick && phase_q && !hold_low_i;
  assign sclk_o      = phase_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + CW'(1);
      if (tick && !hold_low_i) phase_q <= ~phase_q;
    end
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!run_i -> !phase_q)); // R2
  AST_GAP_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_low_i |-> !phase_q); // R7

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int TX_W = 25,
  parameter int RX_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TX_W-1:0] load_val_i,
  input  logic            adv_i,
  input  logic            cap_i,
  input  logic            bit_i,
  output logic            tx_bit_o,
  output logic [RX_W-1:0] rx_word_o
);
  logic [TX_W-1:0] tx_q;
  logic [RX_W-1:0] rx_q;

  assign tx_bit_o  = tx_q[TX_W-1];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)     tx_q <= load_val_i;
      else if (adv_i) tx_q <= {tx_q[TX_W-2:0], 1'b0};
      if (cap_i)      rx_q <= {rx_q[RX_W-2:0], bit_i};
    end
  end

  AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !adv_i && !cap_i); // R4

endmodule

// File: rtl/tws_seq.sv
module tws_seq
  import tws_pkg::*;
#(
  parameter int HDR_W      = 9,
  parameter int DATA_W     = 16,
  parameter int PRE_PULSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_rd_i,
  input  logic addr_ok_i,
  input  logic slot_end_i,
  input  logic half_tick_i,
  input  logic sclk_i,
  output logic ready_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic en_no,
  output logic oe_o,
  output logic run_o,
  output logic hold_low_o,
  output logic tx_load_o,
  output logic tx_adv_o,
  output logic rx_cap_o
);
  localparam int M1   = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int MAXN = (M1 > PRE_PULSES) ? M1 : PRE_PULSES;
  localparam int LW   = $clog2(MAXN + 1);

  seq_state_e    st_q;
  logic [LW-1:0] left_q;
  logic          rd_q, en_n_q, oe_q, done_q, err_q;
  logic          accept, last_slot;

  assign ready_o    = (st_q == ST_IDLE) && !done_q;
  assign accept     = req_valid_i && ready_o;
  assign last_slot  = (left_q == LW'(1));
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign en_no      = en_n_q;
  assign oe_o       = oe_q;
  assign run_o      = (st_q != ST_IDLE);
  assign hold_low_o = (st_q == ST_GAP);
  assign tx_load_o  = accept && addr_ok_i;
  assign tx_adv_o   = slot_end_i && ((st_q == ST_HDR) || (st_q == ST_DATA));
  assign rx_cap_o   = slot_end_i && (st_q == ST_DATA) && rd_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      rd_q   <= 1'b0;
      en_n_q <= 1'b1;
      oe_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (addr_ok_i) begin
              st_q   <= ST_PRE;
              left_q <= LW'(PRE_PULSES);
              rd_q   <= req_rd_i;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        ST_PRE: begin
          if (slot_end_i) begin
            if (last_slot) begin
              st_q   <= ST_HDR;
              left_q <= LW'(HDR_W);
              en_n_q <= 1'b0;
            end else begin
              left_q <= left_q - LW'(1);
            end
          end
        end
        ST_HDR: begin
          if (slot_end_i) begin
            if (last_slot) begin
              if (rd_q) begin
                st_q   <= ST_TURN;
                oe_q   <= 1'b0;
                left_q <= LW'(1);
              end else begin
                st_q   <= ST_DATA;
                left_q <= LW'(DATA_W);
              end
            end else begin
              left_q <= left_q - LW'(1);
            end
          end
        end
        ST_TURN: begin
          if (slot_end_i) begin
            st_q   <= ST_DATA;
            left_q <= LW'(DATA_W);
          end
        end
        ST_DATA: begin
          if (slot_end_i) begin
            if (last_slot) st_q <= ST_GAP;
            else           left_q <= left_q - LW'(1);
          end
        end
        ST_GAP: begin
          if (half_tick_i) begin
            st_q   <= ST_POST;
            en_n_q <= 1'b1;
            oe_q   <= 1'b1;
          end
        end
        ST_POST: begin
          if (slot_end_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_EN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> en_n_q); // R1
  AST_PRE_EN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE) |-> en_n_q); // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_q && st_q != ST_IDLE) |-> oe_q); // R5
  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && (st_q == ST_TURN || st_q == ST_DATA)) |-> !oe_q); // R6
  AST_EN_MOVES_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_n_q) |-> !sclk_i); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q && (st_q == ST_IDLE)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o); // R10

endmodule

// File: rtl/tws_master.sv
module tws_master
  import tws_pkg::*;
#(
  parameter int HALF_CYC   = 2,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 31,
  parameter int PRE_PULSES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              link_clk_o,
  output logic              link_en_no,
  output logic              link_dat_o,
  output logic              link_dat_oe_o,
  input  logic              link_dat_i,
  output logic              link_rst_no
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int TX_W  = HDR_W + DATA_W;

  logic             addr_ok, slot_end, half_tick, sclk;
  logic             run, hold_low, tx_load, tx_adv, rx_cap, tx_bit, oe;
  logic [HDR_W-1:0] hdr;
  logic             prst_q;

  assign addr_ok = addr_valid(32'(req_addr_i), NUM_REGS);
  assign hdr     = HDR_W'(frame_header(req_rd_i, 32'(req_addr_i), ADDR_W));

  tws_clkgen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .hold_low_i (hold_low),
    .sclk_o     (sclk),
    .half_tick_o(half_tick),
    .slot_end_o (slot_end)
  );

  tws_seq #(.HDR_W(HDR_W), .DATA_W(DATA_W), .PRE_PULSES(PRE_PULSES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_rd_i   (req_rd_i),
    .addr_ok_i  (addr_ok),
    .slot_end_i (slot_end),
    .half_tick_i(half_tick),
    .sclk_i     (sclk),
    .ready_o    (req_ready_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .en_no      (link_en_no),
    .oe_o       (oe),
    .run_o      (run),
    .hold_low_o (hold_low),
    .tx_load_o  (tx_load),
    .tx_adv_o   (tx_adv),
    .rx_cap_o   (rx_cap)
  );

  tws_shifter #(.TX_W(TX_W), .RX_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tx_load),
    .load_val_i({hdr, req_wdata_i}),
    .adv_i     (tx_adv),
    .cap_i     (rx_cap),
    .bit_i     (link_dat_i),
    .tx_bit_o  (tx_bit),
    .rx_word_o (rdata_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prst_q <= 1'b0;
    else         prst_q <= 1'b1;
  end

  assign link_clk_o    = sclk;
  assign link_dat_oe_o = oe;
  assign link_dat_o    = tx_bit & oe;
  assign link_rst_no   = prst_q;

  AST_PERIPH_RST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> link_rst_no); // R1
  AST_NO_CLK_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !link_clk_o); // R2

endmodule

// File: tb/sim_tws_master.sv
`timescale 1ns/1ps
module sim_tws_master;
  localparam int H  = 2;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int NR = 31;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_rd, busy, done, err;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rdata;
  logic          lclk, len_n, ldat_o, ldat_oe, ldat_i, lrst_n;

  tws_master #(.HALF_CYC(H), .ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_rd_i(req_rd), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .link_clk_o(lclk), .link_en_no(len_n), .link_dat_o(ldat_o),
    .link_dat_oe_o(ldat_oe), .link_dat_i(ldat_i), .link_rst_no(lrst_n)
  );

  typedef struct {
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          err;
  } exp_t;

  exp_t          q[$];
  logic [DW-1:0] exp_mem [NR];
  logic [DW-1:0] dev_mem [NR];
  int            n_chk = 0;
  int            n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, expv, $time);
    end
  endtask

  // ---------------- monitor and peripheral model ----------------
  logic        clk_p = 1'b0, en_p = 1'b1, done_p = 1'b0;
  int          pre_cnt = 0, post_cnt = 0, ncap = 0, nin = 0, hi_len = 0, lo_len = 0;
  bit          seen_low = 0;
  logic [31:0] cap = '0;

  initial begin
    ldat_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done_p) chk(done == 1'b0, "R8 done width", 32'(done), 0);
        if (lclk && !clk_p) begin
          hi_len = 1;
          chk(busy == 1'b1, "R8 busy during pulse", 32'(busy), 1);
          if (len_n) begin
            if (seen_low) post_cnt++;
            else          pre_cnt++;
          end else begin
            if (!seen_low) chk(pre_cnt == 2, "R3 pulses before enable", 32'(pre_cnt), 2);
            seen_low = 1;
            if (ldat_oe) begin
              cap = {cap[30:0], ldat_o};
              ncap++;
            end else begin
              nin++;
              if (nin >= 2 && nin <= 17 && q.size() > 0)
                ldat_i = dev_mem[q[0].addr][17 - nin];
            end
          end
        end else if (lclk) begin
          hi_len++;
        end else if (!lclk && clk_p) begin
          chk(hi_len == H, "R2 high phase length", 32'(hi_len), H);
          lo_len = 1;
        end else begin
          if (len_n && !en_p && seen_low) begin
            chk(lo_len == H, "R7 gap before enable rise", 32'(lo_len), H);
            chk(ldat_oe == 1'b1, "R7 pad driven again", 32'(ldat_oe), 1);
          end
          lo_len++;
        end
        if (done) begin
          if (q.size() == 0) begin
            chk(1'b0, "R10 unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(err == e.err, "R9 err flag", 32'(err), 32'(e.err));
            chk(busy == 1'b0, "R8 busy low at done", 32'(busy), 0);
            if (e.err) begin
              chk(pre_cnt == 0 && !seen_low, "R9 no link activity",
                  32'(pre_cnt), 0);
            end else begin
              logic [8:0] hdr;
              hdr = {1'b0, e.rd, e.addr};
              chk(post_cnt == 1, "R7 trailing pulse count", 32'(post_cnt), 1);
              if (e.rd) begin
                chk(ncap == 9, "R6 driven bits on read", 32'(ncap), 9);
                chk(cap[8:0] == hdr, "R4 read header", cap[8:0], 32'(hdr));
                chk(nin == 17, "R6 released pulses", 32'(nin), 17);
                chk(rdata == e.rdata, "R6 read word", 32'(rdata), 32'(e.rdata));
              end else begin
                chk(ncap == 25, "R5 driven bits on write", 32'(ncap), 25);
                chk(cap[24:16] == hdr, "R4 write header", cap[24:16], 32'(hdr));
                chk(cap[15:0] == e.wdata, "R5 write data", cap[15:0], 32'(e.wdata));
                dev_mem[e.addr] = cap[15:0];
              end
            end
          end
          pre_cnt = 0; post_cnt = 0; ncap = 0; nin = 0; seen_low = 0; cap = '0;
        end
      end
      clk_p  = lclk;
      en_p   = len_n;
      done_p = done;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input bit noise);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.rd    = rd;
    e.addr  = a;
    e.wdata = wd;
    e.err   = (a >= AW'(NR));
    e.rdata = (!e.err && rd) ? exp_mem[a] : '0;
    if (!e.err && !rd) exp_mem[a] = wd;
    q.push_back(e);
    req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (noise) begin
      repeat (4) @(negedge clk);
      for (int k = 0; k < 10; k++) begin
        req_valid = 1'b1; req_rd = ~rd; req_addr = AW'(k + 3); req_wdata = 16'hDEAD;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready low while busy", 32'(req_ready), 0);
      end
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      exp_mem[i] = 16'h1357 ^ DW'(i * 16'h0111);
      dev_mem[i] = 16'h1357 ^ DW'(i * 16'h0111);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_rd = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(lrst_n == 1'b0, "R1 periph reset low in reset", 32'(lrst_n), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(len_n == 1'b1, "R1 enable idle", 32'(len_n), 1);
    chk(lclk == 1'b0, "R1 clock idle", 32'(lclk), 0);
    chk(ldat_oe == 1'b1, "R1 pad driven", 32'(ldat_oe), 1);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done idle", 32'({busy, done}), 0);
    chk(req_ready == 1'b1, "R1 ready idle", 32'(req_ready), 1);
    chk(lrst_n == 1'b1, "R1 periph reset released", 32'(lrst_n), 1);

    send(1'b1, 7'd12, '0, 1'b0);        // R6 read of untouched register
    send(1'b0, 7'd0, 16'hFFFF, 1'b0);   // R5 all ones
    send(1'b0, 7'd30, 16'h0000, 1'b0);  // R5 highest valid address
    send(1'b0, 7'd5, 16'hA5C3, 1'b0);
    send(1'b1, 7'd0, '0, 1'b0);
    send(1'b1, 7'd30, '0, 1'b0);
    send(1'b1, 7'd5, '0, 1'b0);
    send(1'b0, 7'd31, 16'h1234, 1'b0);  // R9 first invalid address
    send(1'b1, 7'd127, '0, 1'b0);       // R9 top of address range
    send(1'b0, 7'd9, 16'h8001, 1'b1);   // R10 requests while busy
    send(1'b1, 7'd9, '0, 1'b1);         // R10 during a read
    send(1'b1, 7'd3, '0, 1'b0);         // R10 earlier noise must not have written
    send(1'b0, 7'd17, 16'h5AF0, 1'b0);
    send(1'b1, 7'd17, '0, 1'b0);

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule